// File: doc/BRIEF.md
# Dual-Path Error-Feedback Requantizer

This block takes the 16-level result of a fine quantizer and turns each sample into two coarse codes for the reduced-level feedback converters of a second-order modulator loop. One code has three levels (step = 8 input LSB) and drives the main feedback converter. The other has five levels (step = 4 input LSB) and drives the converter of the second integrator. Each path adds its own stored truncation error back into the incoming word before it rounds. This is error feedback, and it pushes the truncation noise to high frequencies.

The coarse codes come out with no register in the forward path. The current input, together with the error state held in registers, sets the codes within the same cycle. Each path also reports its exact truncation error one cycle later, so that downstream logic can cancel it. A mode input selects first-order shaping (one error delay) or second-order shaping (two delays, weights 2 and -1). In second-order mode, the stored error term is limited to one coarse step in either direction, which keeps the loop bounded.

Top module: `rq_requantizer`

## Requirements
- R1: `in_code` is offset binary: the sample value is `in_code - 8`, so 4'b0000 means -8 LSB and 4'b1111 means +7 LSB.
- R2: Path A rounds the shaped word w to the nearest multiple of 8, with ties toward zero, and saturates at ±1 step. `code_a` is 2-bit two's complement: 2'b11 = -1, 2'b00 = 0, 2'b01 = +1.
- R3: Path B rounds w to the nearest multiple of 4, with ties toward zero, and saturates at ±2 half-steps. `code_b` is 3-bit two's complement in half-steps, ranging from -2 to +2.
- R4: Both codes depend on the current `in_code` and the stored state within the same cycle, with no forward register.
- R5: With `order2` = 0, each path uses w = x + e1, where e1 is that path's most recently stored feedback term.
- R6: With `order2` = 1, each path uses w = x + 2·e1 - e2, where e2 is the term stored before e1. Both delays always track the last two stored terms, whatever the mode.
- R7: The exported error of a path is w minus the coarse level in input LSB (code × step), without any limiting. It appears on `err_a` / `err_b` (7-bit two's complement) in the cycle after the sample.
- R8: The term stored for feedback is the exported error limited to [-step, +step]: ±8 for path A and ±4 for path B.
- R9: State and error ports advance only on cycles with `in_valid` high. `err_valid` equals `in_valid` of the previous cycle, and the error ports hold their value otherwise.
- R10: A low `rst_n` at a clock edge (synchronous) clears the error state, the error ports and `err_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_code` for this cycle |
| in_code | input | 4 | Fine quantizer code, offset binary |
| order2 | input | 1 | 0 = first-order shaping, 1 = second-order shaping |
| code_a | output | 2 | Three-level code, combinational |
| code_b | output | 3 | Five-level code in half-steps, combinational |
| err_valid | output | 1 | Error ports carry a new sample |
| err_a | output | 7 | Path A truncation error of previous sample |
| err_b | output | 7 | Path B truncation error of previous sample |

## Verification
Saturation of a coarse code and limiting of the stored feedback term can happen in the same sample. When that occurs, the exported error and the next feedback value differ from each other. Bursts of full-scale codes alternating in second-order mode drive the shaped word past the outer levels and provoke this case. The behavioural model then judges the coarse code of that sample, the exact unlimited error exported one cycle later, and the code of the next sample, which exposes whether the limited term was the one fed back.

// File: rtl/rq_pkg.sv
// Shared definitions for the requantizer: default widths and the shaping-order type.
// Assumes a 4-bit fine code and power-of-two coarse steps.
package rq_pkg;
    typedef enum logic {
        SHAPE_1ST = 1'b0,
        SHAPE_2ND = 1'b1
    } shape_order_e;

    localparam int IN_W_DEF  = 4;
    localparam int ACC_W_DEF = 6;
endpackage

// File: rtl/rq_quant.sv
// Rounds a signed shaped word to the nearest multiple of STEP, with ties toward zero,
// and saturates to +/-LVL steps. Purely combinational. Assumes STEP is a power of two.
module rq_quant #(
    parameter int ACC_W  = 6,
    parameter int ERR_W  = 7,
    parameter int CODE_W = 2,
    parameter int STEP   = 8,
    parameter int LVL    = 1
) (
    input  logic signed [ACC_W-1:0]  word,
    output logic signed [CODE_W-1:0] code,
    output logic signed [ERR_W-1:0]  level
);
    localparam int SH   = $clog2(STEP);
    localparam int HALF = STEP / 2;

    logic                    neg;
    logic signed [ACC_W:0]   wx;
    logic        [ACC_W:0]   mag;
    logic        [ACC_W:0]   biased;
    logic        [ACC_W:0]   qmag;
    logic        [ACC_W:0]   qsat;
    logic signed [CODE_W-1:0] cpos;
    logic signed [ERR_W-1:0]  lvl_ext;

    // Magnitude rounding with ties toward zero, then saturation and sign restore.
    always_comb begin
        neg     = word[ACC_W-1];
        wx      = {word[ACC_W-1], word};
        mag     = neg ? $unsigned(-wx) : $unsigned(wx);
        biased  = mag + (ACC_W+1)'(HALF - 1);
        qmag    = biased >> SH;
        qsat    = (qmag > (ACC_W+1)'(LVL)) ? (ACC_W+1)'(LVL) : qmag;
        cpos    = CODE_W'(qsat);
        code    = neg ? -cpos : cpos;
        lvl_ext = ERR_W'(code);
        level   = lvl_ext <<< SH;
    end
endmodule

// File: rtl/rq_shaper.sv
// One requantizer path: error-feedback shaping of first or second order, a
// delay-free coarse code, and the exact error registered for export.
// Assumes |x| <= 8 so the shaped word fits ACC_W bits with the limited state.
module rq_shaper
    import rq_pkg::*;
#(
    parameter int ACC_W  = 6,
    parameter int ERR_W  = 7,
    parameter int CODE_W = 2,
    parameter int STEP   = 8,
    parameter int LVL    = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    input  shape_order_e             order,
    input  logic signed [ACC_W-1:0]  x,
    output logic signed [CODE_W-1:0] code,
    output logic signed [ERR_W-1:0]  err_q
);
    localparam logic signed [ERR_W-1:0] LIM = ERR_W'(STEP);

    logic signed [ACC_W-1:0] e1, e2;
    logic signed [ERR_W-1:0] xx, e1x, e2x, sum, err_now, fb;
    logic signed [ACC_W-1:0] word;
    logic signed [ERR_W-1:0] level;

    // Shaped word: input plus weighted history of stored error terms.
    always_comb begin
        xx   = ERR_W'(x);
        e1x  = ERR_W'(e1);
        e2x  = ERR_W'(e2);
        sum  = (order == SHAPE_2ND) ? xx + (e1x <<< 1) - e2x : xx + e1x;
        word = ACC_W'(sum);
    end

    rq_quant #(
        .ACC_W (ACC_W),
        .ERR_W (ERR_W),
        .CODE_W(CODE_W),
        .STEP  (STEP),
        .LVL   (LVL)
    ) u_quant (
        .word (word),
        .code (code),
        .level(level)
    );

    // Exact truncation error and its limited copy for the feedback state.
    always_comb begin
        err_now = ERR_W'(word) - level;
        if (err_now > LIM)
            fb = LIM;
        else if (err_now < -LIM)
            fb = -LIM;
        else
            fb = err_now;
    end

    // Error history and exported error advance on qualified samples only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e1    <= '0;
            e2    <= '0;
            err_q <= '0;
        end else if (adv) begin
            e2    <= e1;
            e1    <= ACC_W'(fb);
            err_q <= err_now;
        end
    end
endmodule

// File: rtl/rq_requantizer.sv
// Top of the dual-path requantizer: maps the offset-binary fine code to signed,
// feeds a three-level path and a five-level path, and times the error export.
// Assumes a 4-bit input; the coarse codes are combinational, the errors registered.
module rq_requantizer
    import rq_pkg::*;
#(
    parameter int IN_W     = IN_W_DEF,
    parameter int ACC_W    = ACC_W_DEF,
    parameter int STEP_A   = 8,
    parameter int LVL_A    = 1,
    parameter int STEP_B   = 4,
    parameter int LVL_B    = 2,
    parameter int CODE_A_W = 2,
    parameter int CODE_B_W = 3,
    parameter int ERR_W    = ACC_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [IN_W-1:0]     in_code,
    input  logic                order2,
    output logic [CODE_A_W-1:0] code_a,
    output logic [CODE_B_W-1:0] code_b,
    output logic                err_valid,
    output logic [ERR_W-1:0]    err_a,
    output logic [ERR_W-1:0]    err_b
);
    logic signed [ACC_W-1:0]    x;
    logic signed [CODE_A_W-1:0] ca;
    logic signed [CODE_B_W-1:0] cb;
    logic signed [ERR_W-1:0]    ea, eb;
    shape_order_e               order;

    // Offset binary to two's complement by inverting the top bit.
    always_comb begin
        x     = ACC_W'($signed({~in_code[IN_W-1], in_code[IN_W-2:0]}));
        order = shape_order_e'(order2);
    end

    rq_shaper #(
        .ACC_W(ACC_W), .ERR_W(ERR_W), .CODE_W(CODE_A_W), .STEP(STEP_A), .LVL(LVL_A)
    ) u_path_a (
        .clk(clk), .rst_n(rst_n), .adv(in_valid), .order(order),
        .x(x), .code(ca), .err_q(ea)
    );

    rq_shaper #(
        .ACC_W(ACC_W), .ERR_W(ERR_W), .CODE_W(CODE_B_W), .STEP(STEP_B), .LVL(LVL_B)
    ) u_path_b (
        .clk(clk), .rst_n(rst_n), .adv(in_valid), .order(order),
        .x(x), .code(cb), .err_q(eb)
    );

    // Drive the port-side views of both paths.
    always_comb begin
        code_a = ca;
        code_b = cb;
        err_a  = ea;
        err_b  = eb;
    end

    // Error-port qualifier trails the input qualifier by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_valid <= 1'b0;
        else
            err_valid <= in_valid;
    end
endmodule

// File: rtl/rq_requantizer_chk.sv
// Property checker for rq_requantizer: code ranges, error-port timing and reset.
module rq_requantizer_chk #(
    parameter int CODE_A_W = 2,
    parameter int CODE_B_W = 3,
    parameter int ERR_W    = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [CODE_A_W-1:0] code_a,
    input logic [CODE_B_W-1:0] code_b,
    input logic                err_valid,
    input logic [ERR_W-1:0]    err_a,
    input logic [ERR_W-1:0]    err_b
);
    assert_code_a_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(code_a) >= -1) && ($signed(code_a) <= 1));

    assert_code_b_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(code_b) >= -2) && ($signed(code_b) <= 2));

    assert_err_valid_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> err_valid);

    assert_err_valid_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !err_valid);

    assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(err_a) && $stable(err_b)));

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (!err_valid && err_a == '0 && err_b == '0));
endmodule

bind rq_requantizer rq_requantizer_chk #(
    .CODE_A_W(CODE_A_W), .CODE_B_W(CODE_B_W), .ERR_W(ERR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .code_a(code_a), .code_b(code_b),
    .err_valid(err_valid), .err_a(err_a), .err_b(err_b)
);

// File: tb/sim_rq_requantizer.sv
`timescale 1ns/1ps
module sim_rq_requantizer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] in_code = 4'd0;
    logic       order2 = 1'b0;
    logic [1:0] code_a;
    logic [2:0] code_b;
    logic       err_valid;
    logic [6:0] err_a, err_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state per path: index 0 = path A, 1 = path B
    int m_e1[2], m_e2[2], m_err[2];
    int m_ev;
    bit prev_rst;
    bit prev_clamp;
    int lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    rq_requantizer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code), .order2(order2),
        .code_a(code_a), .code_b(code_b), .err_valid(err_valid), .err_a(err_a), .err_b(err_b)
    );

    function automatic int rnd(input int w, input int step, input int lvl);
        int mag, q;
        mag = (w < 0) ? -w : w;
        q = (mag + step/2 - 1) / step;
        if (q > lvl) q = lvl;
        return (w < 0) ? -q : q;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit rst, input bit v, input int code, input bit ord);
        int steps[2], lvls[2], w[2], q[2], e[2], fb[2];
        string tg;
        steps[0] = 8; lvls[0] = 1; steps[1] = 4; lvls[1] = 2;
        @(posedge clk);
        #1;
        rst_n = rst; in_valid = v; in_code = 4'(code); order2 = ord;
        #1;
        // R1: sample value is in_code - 8
        for (int p = 0; p < 2; p++) begin
            w[p] = (code - 8) + (ord ? 2*m_e1[p] - m_e2[p] : m_e1[p]);
            q[p] = rnd(w[p], steps[p], lvls[p]);
            e[p] = w[p] - q[p]*steps[p];
            fb[p] = (e[p] > steps[p]) ? steps[p] : ((e[p] < -steps[p]) ? -steps[p] : e[p]);
        end
        tg = prev_clamp ? "R8" : (ord ? "R6" : "R5");
        check({"R2/R4 code_a ", tg}, $signed(code_a), q[0]);
        check({"R3/R4 code_b ", tg}, $signed(code_b), q[1]);
        tg = prev_rst ? "R10" : "R7";
        check({"R9 err_valid ", tg}, int'(err_valid), m_ev);
        check({"err_a ", tg}, $signed(err_a), m_err[0]);
        check({"err_b ", tg}, $signed(err_b), m_err[1]);
        // model advances at the coming edge
        prev_rst = !rst;
        if (!rst) begin
            for (int p = 0; p < 2; p++) begin m_e1[p] = 0; m_e2[p] = 0; m_err[p] = 0; end
            m_ev = 0;
            prev_clamp = 0;
        end else begin
            m_ev = v;
            if (v) begin
                prev_clamp = (fb[0] != e[0]) || (fb[1] != e[1]);
                for (int p = 0; p < 2; p++) begin
                    m_e2[p] = m_e1[p]; m_e1[p] = fb[p]; m_err[p] = e[p];
                end
            end
        end
    endtask

    function automatic int next_rnd();
        lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
        return lfsr;
    endfunction

    initial begin
        for (int p = 0; p < 2; p++) begin m_e1[p] = 0; m_e2[p] = 0; m_err[p] = 0; end
        m_ev = 0; prev_rst = 1; prev_clamp = 0;
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        // R1 extremes from a cleared state, first order
        cyc(1, 1, 0, 0);   // x=-8: code_a -1, code_b -2
        cyc(0, 0, 0, 0);
        cyc(1, 1, 15, 0);  // x=+7: code_a +1, code_b +2
        cyc(0, 0, 0, 0);
        // ties toward zero (R2: w=4 -> 0, R3: w=2 -> 0)
        cyc(1, 1, 12, 0);
        cyc(0, 0, 0, 0);
        cyc(1, 1, 4, 0);
        cyc(0, 0, 0, 0);
        cyc(1, 1, 10, 0);
        // R9 hold: invalid cycles with changing input
        cyc(1, 0, 15, 0);
        cyc(1, 0, 3, 1);
        cyc(1, 1, 9, 0);
        // first-order ramp and random
        for (int i = 0; i < 40; i++) cyc(1, 1, i % 16, 0);
        for (int i = 0; i < 400; i++) begin
            int r = next_rnd();
            cyc(1, (r & 7) != 0, (r >> 4) & 15, 0);
        end
        // second order: alternating full-scale bursts provoke saturation and limiting
        for (int i = 0; i < 200; i++) cyc(1, 1, (i % 2) ? 15 : 0, 1);
        for (int i = 0; i < 100; i++) cyc(1, 1, ((i / 3) % 2) ? 15 : 0, 1);
        for (int i = 0; i < 600; i++) begin
            int r = next_rnd();
            cyc(1, (r & 3) != 0, (r >> 5) & 15, ((r >> 9) & 1) == 1);
        end
        // R10 mid-run reset then resume
        cyc(0, 1, 15, 1);
        cyc(1, 1, 7, 1);
        for (int i = 0; i < 50; i++) cyc(1, 1, 15, 1);
        cyc(1, 0, 0, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule